// File: doc/BRIEF.md
# Boot-subset 8-bit CPU core

This block is a small multi-cycle 8-bit processor. It carries just enough of an instruction set to run the first stretch of a power-on program. That program sets the stack pointer, clears a region of memory in a loop, writes a handful of values into the I/O page at the top of the address space, and then starts reading a cartridge header. The core keeps an accumulator A, a flag register F, the byte registers B, C, D, E, H and L, a 16-bit stack pointer and a 16-bit program counter. It talks to a single byte-wide memory over a 16-bit address, with separate read and write strobes. Read data is expected to be valid in the same cycle as the read strobe.

Every instruction takes its cycle cost from a fixed table. The core adds that cost to a running counter on the instruction's last clock. Software that models timing can read the counter to see how far the program has advanced. Any opcode outside the supported subset stops the core for good and raises a flag. The flag stays up until the next reset. The architectural registers are brought out on observation ports so the surrounding system can follow the program's progress.

Top module: `bootcpu`

## Requirements
- R1: A synchronous active-low reset clears every register, the program counter, the stack pointer, the cycle counter and the illegal flag. Each instruction runs as follows: one opcode read at PC, then one cycle with neither strobe active, then its operand reads at consecutive addresses, then at most one data access.
- R2: Opcodes 0x01, 0x11, 0x21 and 0x31 load a 16-bit immediate into BC, DE, HL or SP. The pair is chosen by opcode bits 5:4, where 0 = BC, 1 = DE, 2 = HL and 3 = SP. The low byte comes first, PC ends up past both operand bytes, and the cost is 8.
- R3: Opcode 0xAF clears A and sets F to 0x80 (Z set, all other flags clear). The cost is 4.
- R4: Opcode 0x32 writes A to the address in HL and then decrements HL by one. The cost is 8.
- R5: Opcode 0x77 writes A to the address in HL and leaves HL unchanged. The cost is 8.
- R6: The byte pair 0xCB 0x7C sets Z to the inverse of bit 7 of H, clears N, sets half-carry and keeps carry. H is left unchanged and the cost is 8.
- R7: Opcode 0x20 reads a signed byte operand. When Z is clear, PC becomes the address after the operand plus that signed value and the cost is 16. When Z is set, PC continues after the operand and the cost is 12.
- R8: Opcodes 0x0E and 0x3E load an immediate byte into C and A respectively. The cost is 8.
- R9: Opcode 0x0C increments C. It sets Z when the result is zero, clears N, sets half-carry when the low nibble carries out, and keeps carry. The cost is 4.
- R10: Opcode 0xE2 writes A to 0xFF00 + C at a cost of 8. Opcode 0xE0 reads a byte n and writes A to 0xFF00 + n at a cost of 12.
- R11: Opcode 0x1A reads the byte at the address in DE into A. The cost is 8.
- R12: Any other opcode, and any byte other than 0x7C after 0xCB, stops the core. From then on the illegal flag is high, neither strobe is active, and no register changes.
- R13: F holds Z in bit 7, N in bit 6, half-carry in bit 5 and carry in bit 4, and its low nibble is always zero. The read and write strobes are never active together, and the counter only moves in steps of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| memRData | input | 8 | Read data, valid in the cycle memRd is high |
| memAddr | output | 16 | Bus address |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memWData | output | 8 | Write data (the accumulator) |
| illegalOp | output | 1 | High once an unsupported opcode has stopped the core |
| cycleCount | output | CYC_W | Accumulated instruction cycle cost |
| pcOut | output | 16 | Program counter |
| spOut | output | 16 | Stack pointer |
| regAF | output | 16 | A in the upper byte, F in the lower byte |
| regBC | output | 16 | B and C |
| regDE | output | 16 | D and E |
| regHL | output | 16 | H and L |

## Verification
The hardest behaviour to reach from the ports is the conditional relative jump. The branch has to be taken backwards several times and then fall through. That only happens after a store-and-decrement has walked HL across the point where bit 7 of H changes, with the bit test feeding the loop each time. The stimulus runs a clear loop that starts HL a few bytes above 0x8000, so the loop runs several taken iterations and then one not-taken exit within a few dozen cycles. A second program covers the remaining cases: the flag corners of the increment (wrap to zero, nibble carry), a forward taken jump over unsupported bytes, and a prefix with the wrong second byte.

// File: rtl/bootcpu_pkg.sv
package bootcpu_pkg;

  localparam logic [7:0] IO_PAGE_HI = 8'hFF;
  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_C = 4;

  typedef enum logic [2:0] {
    ASEL_PC,
    ASEL_HL,
    ASEL_DE,
    ASEL_IOC,
    ASEL_IOIMM
  } addrSel_e;

  typedef struct packed {
    addrSel_e   addrSel;
    logic       memRd;
    logic       memWr;
    logic       pcInc;
    logic       latchLo;
    logic       ldPair;
    logic [1:0] pairSel;
    logic       ldA;
    logic       ldC;
    logic       xorA;
    logic       incC;
    logic       bitH;
    logic       decHL;
    logic       jrCheck;
    logic [4:0] cost;
  } strobe_t;

endpackage

// File: rtl/bootcpu_ctrl.sv
module bootcpu_ctrl
  import bootcpu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] memRData,
  output strobe_t    st,
  output logic       halted
);

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_IMM_LO, S_IMM_HI, S_WRITE, S_LOAD, S_CB, S_HALT
  } state_e;

  state_e     state, stateNext;
  logic [7:0] ir;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_FETCH;
      ir    <= 8'h00;
    end else begin
      state <= stateNext;
      if (state == S_FETCH) ir <= memRData;
    end
  end

  always_comb begin
    st        = '0;
    st.addrSel = ASEL_PC;
    stateNext = state;
    case (state)
      S_FETCH: begin
        st.memRd  = 1'b1;
        st.pcInc  = 1'b1;
        stateNext = S_DECODE;
      end
      S_DECODE: begin
        case (ir)
          8'h01, 8'h11, 8'h21, 8'h31,
          8'h0E, 8'h3E, 8'h20, 8'hE0: stateNext = S_IMM_LO;
          8'hAF: begin
            st.xorA   = 1'b1;
            st.cost   = 5'd4;
            stateNext = S_FETCH;
          end
          8'h0C: begin
            st.incC   = 1'b1;
            st.cost   = 5'd4;
            stateNext = S_FETCH;
          end
          8'h32, 8'h77, 8'hE2: stateNext = S_WRITE;
          8'h1A:               stateNext = S_LOAD;
          8'hCB:               stateNext = S_CB;
          default:             stateNext = S_HALT;
        endcase
      end
      S_IMM_LO: begin
        st.memRd = 1'b1;
        case (ir)
          8'h0E: begin
            st.ldC = 1'b1; st.pcInc = 1'b1; st.cost = 5'd8; stateNext = S_FETCH;
          end
          8'h3E: begin
            st.ldA = 1'b1; st.pcInc = 1'b1; st.cost = 5'd8; stateNext = S_FETCH;
          end
          8'h20: begin
            st.jrCheck = 1'b1; stateNext = S_FETCH;
          end
          8'hE0: begin
            st.latchLo = 1'b1; st.pcInc = 1'b1; stateNext = S_WRITE;
          end
          default: begin
            st.latchLo = 1'b1; st.pcInc = 1'b1; stateNext = S_IMM_HI;
          end
        endcase
      end
      S_IMM_HI: begin
        st.memRd   = 1'b1;
        st.pcInc   = 1'b1;
        st.ldPair  = 1'b1;
        st.pairSel = ir[5:4];
        st.cost    = 5'd8;
        stateNext  = S_FETCH;
      end
      S_WRITE: begin
        st.memWr  = 1'b1;
        st.cost   = 5'd8;
        stateNext = S_FETCH;
        case (ir)
          8'h32: begin st.addrSel = ASEL_HL; st.decHL = 1'b1; end
          8'h77: st.addrSel = ASEL_HL;
          8'hE2: st.addrSel = ASEL_IOC;
          default: begin st.addrSel = ASEL_IOIMM; st.cost = 5'd12; end
        endcase
      end
      S_LOAD: begin
        st.addrSel = ASEL_DE;
        st.memRd   = 1'b1;
        st.ldA     = 1'b1;
        st.cost    = 5'd8;
        stateNext  = S_FETCH;
      end
      S_CB: begin
        st.memRd = 1'b1;
        st.pcInc = 1'b1;
        if (memRData == 8'h7C) begin
          st.bitH   = 1'b1;
          st.cost   = 5'd8;
          stateNext = S_FETCH;
        end else begin
          stateNext = S_HALT;
        end
      end
      default: stateNext = S_HALT;
    endcase
  end

  assign halted = (state == S_HALT);

  // R13: the two strobes never overlap
  p_bus_excl_r13: assert property (@(posedge clk) disable iff (!rstN)
    !(st.memRd && st.memWr));

  // R12: a stopped core stays stopped and silent
  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && !st.memRd && !st.memWr));

endmodule

// File: rtl/bootcpu_dp.sv
module bootcpu_dp
  import bootcpu_pkg::*;
#(
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [7:0]       memRData,
  output logic [15:0]      memAddr,
  output logic [7:0]       memWData,
  output logic [CYC_W-1:0] cycles,
  output logic [15:0]      pc,
  output logic [15:0]      sp,
  output logic [15:0]      af,
  output logic [15:0]      bc,
  output logic [15:0]      de,
  output logic [15:0]      hl
);

  logic [7:0]  regA, regF, regB, regC, regD, regE, regH, regL, tmpLo;
  logic [15:0] pcNext, jrTarget;
  logic [4:0]  costNow;
  logic        jrTaken;
  logic [7:0]  incRes, xorRes;

  always_comb begin
    case (st.addrSel)
      ASEL_HL:    memAddr = {regH, regL};
      ASEL_DE:    memAddr = {regD, regE};
      ASEL_IOC:   memAddr = {IO_PAGE_HI, regC};
      ASEL_IOIMM: memAddr = {IO_PAGE_HI, tmpLo};
      default:    memAddr = pc;
    endcase
  end

  assign memWData = regA;
  assign jrTaken  = !regF[FLAG_Z];
  assign jrTarget = pc + 16'd1 + {{8{memRData[7]}}, memRData};
  assign incRes   = regC + 8'd1;
  assign xorRes   = regA ^ regA;

  always_comb begin
    if (st.jrCheck) begin
      pcNext  = jrTaken ? jrTarget : pc + 16'd1;
      costNow = jrTaken ? 5'd16 : 5'd12;
    end else begin
      pcNext  = st.pcInc ? pc + 16'd1 : pc;
      costNow = st.cost;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA <= '0; regF <= '0; regB <= '0; regC <= '0;
      regD <= '0; regE <= '0; regH <= '0; regL <= '0;
      tmpLo <= '0; pc <= '0; sp <= '0; cycles <= '0;
    end else begin
      pc     <= pcNext;
      cycles <= cycles + CYC_W'(costNow);
      if (st.latchLo) tmpLo <= memRData;
      if (st.ldPair) begin
        case (st.pairSel)
          2'd0: begin regB <= memRData; regC <= tmpLo; end
          2'd1: begin regD <= memRData; regE <= tmpLo; end
          2'd2: begin regH <= memRData; regL <= tmpLo; end
          default: sp <= {memRData, tmpLo};
        endcase
      end
      if (st.ldA) regA <= memRData;
      if (st.ldC) regC <= memRData;
      if (st.decHL) {regH, regL} <= {regH, regL} - 16'd1;
      if (st.xorA) begin
        regA <= xorRes;
        regF <= {(xorRes == 8'h00), 3'b000, 4'h0};
      end else if (st.incC) begin
        regC <= incRes;
        regF <= {(incRes == 8'h00), 1'b0, (regC[3:0] == 4'hF), regF[FLAG_C], 4'h0};
      end else if (st.bitH) begin
        regF <= {!regH[7], 1'b0, 1'b1, regF[FLAG_C], 4'h0};
      end
    end
  end

  assign af = {regA, regF};
  assign bc = {regB, regC};
  assign de = {regD, regE};
  assign hl = {regH, regL};

  // R13: low nibble of the flag register stays clear
  p_flag_low_zero_r13: assert property (@(posedge clk) disable iff (!rstN)
    regF[3:0] == 4'h0);

  // R13: counter advances only in multiples of four
  p_cost_step_r13: assert property (@(posedge clk) disable iff (!rstN)
    ((cycles - $past(cycles)) & CYC_W'(3)) == '0);

  // R4: store-and-decrement leaves HL one lower
  p_hl_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.decHL |=> ({regH, regL} == $past({regH, regL}) - 16'd1));

  // R6: the bit test does not alter H
  p_h_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.bitH |=> (regH == $past(regH)));

  // R9: increment keeps the carry flag
  p_carry_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.incC |=> (regF[FLAG_C] == $past(regF[FLAG_C])));

endmodule

// File: rtl/bootcpu.sv
module bootcpu
  import bootcpu_pkg::*;
#(
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       memRData,
  output logic [15:0]      memAddr,
  output logic             memRd,
  output logic             memWr,
  output logic [7:0]       memWData,
  output logic             illegalOp,
  output logic [CYC_W-1:0] cycleCount,
  output logic [15:0]      pcOut,
  output logic [15:0]      spOut,
  output logic [15:0]      regAF,
  output logic [15:0]      regBC,
  output logic [15:0]      regDE,
  output logic [15:0]      regHL
);

  strobe_t st;

  bootcpu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .memRData (memRData),
    .st       (st),
    .halted   (illegalOp)
  );

  bootcpu_dp #(.CYC_W(CYC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .memRData (memRData),
    .memAddr  (memAddr),
    .memWData (memWData),
    .cycles   (cycleCount),
    .pc       (pcOut),
    .sp       (spOut),
    .af       (regAF),
    .bc       (regBC),
    .de       (regDE),
    .hl       (regHL)
  );

  assign memRd = st.memRd;
  assign memWr = st.memWr;

endmodule

// File: tb/bootcpu_test.sv
module bootcpu_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  memRData = 8'h00;
  logic [15:0] memAddr;
  logic        memRd, memWr, illegalOp;
  logic [7:0]  memWData;
  logic [31:0] cycleCount;
  logic [15:0] pcOut, spOut, regAF, regBC, regDE, regHL;

  always #(CLK_PERIOD/2) clk = ~clk;

  bootcpu #(.CYC_W(32)) uut (
    .clk(clk), .rstN(rstN), .memRData(memRData), .memAddr(memAddr),
    .memRd(memRd), .memWr(memWr), .memWData(memWData), .illegalOp(illegalOp),
    .cycleCount(cycleCount), .pcOut(pcOut), .spOut(spOut), .regAF(regAF),
    .regBC(regBC), .regDE(regDE), .regHL(regHL)
  );

  int nRun = 0;
  int nFail = 0;

  bit [7:0] busMem [bit [15:0]];
  bit [7:0] refMem [bit [15:0]];

  // reference machine state
  logic [7:0]  mA, mF, mB, mC, mD, mE, mH, mL;
  logic [15:0] mSP, mPC;
  logic [31:0] mCyc;
  bit          mHalt;
  string       lastTag;

  // expected bus activity, one entry per clock: 0 idle, 1 read, 2 write
  int          qKind[$];
  logic [15:0] qAddr[$];
  logic [7:0]  qData[$];
  string       qTag[$];

  function automatic bit [7:0] busRead(input logic [15:0] a);
    return busMem.exists(a) ? busMem[a] : 8'h00;
  endfunction

  function automatic bit [7:0] refRead(input logic [15:0] a);
    return refMem.exists(a) ? refMem[a] : 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input string act, input string exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
    end
  endtask

  task automatic pushBus(input int k, input logic [15:0] a, input logic [7:0] d, input string t);
    qKind.push_back(k); qAddr.push_back(a); qData.push_back(d); qTag.push_back(t);
  endtask

  function automatic string tagOf(input logic [7:0] op);
    case (op)
      8'h01, 8'h11, 8'h21, 8'h31: return "R2";
      8'hAF: return "R3";
      8'h32: return "R4";
      8'h77: return "R5";
      8'hCB: return "R6";
      8'h20: return "R7";
      8'h0E, 8'h3E: return "R8";
      8'h0C: return "R9";
      8'hE2, 8'hE0: return "R10";
      8'h1A: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic refReset();
    mA = 0; mF = 0; mB = 0; mC = 0; mD = 0; mE = 0; mH = 0; mL = 0;
    mSP = 0; mPC = 0; mCyc = 0; mHalt = 0; lastTag = "R1";
    qKind.delete(); qAddr.delete(); qData.delete(); qTag.delete();
  endtask

  task automatic refWrite(input logic [15:0] a, input string t);
    refMem[a] = mA;
    pushBus(2, a, mA, t);
  endtask

  // behavioural execution of one instruction, queuing its bus cycles
  task automatic execInstr();
    logic [7:0] op, lo, hi, b;
    string t;
    bit hc;
    op = refRead(mPC);
    t = tagOf(op);
    pushBus(1, mPC, 8'h00, t);
    mPC = mPC + 1;
    pushBus(0, 16'h0, 8'h00, t);
    case (op)
      8'h01, 8'h11, 8'h21, 8'h31: begin
        lo = refRead(mPC); pushBus(1, mPC, 0, t); mPC = mPC + 1;
        hi = refRead(mPC); pushBus(1, mPC, 0, t); mPC = mPC + 1;
        case (op[5:4])
          2'd0: begin mB = hi; mC = lo; end
          2'd1: begin mD = hi; mE = lo; end
          2'd2: begin mH = hi; mL = lo; end
          default: mSP = {hi, lo};
        endcase
        mCyc = mCyc + 8;
      end
      8'hAF: begin mA = 8'h00; mF = 8'h80; mCyc = mCyc + 4; end
      8'h32: begin
        refWrite({mH, mL}, t);
        {mH, mL} = {mH, mL} - 16'd1;
        mCyc = mCyc + 8;
      end
      8'h77: begin refWrite({mH, mL}, t); mCyc = mCyc + 8; end
      8'hCB: begin
        b = refRead(mPC); pushBus(1, mPC, 0, t); mPC = mPC + 1;
        if (b == 8'h7C) begin
          mF = {~mH[7], 1'b0, 1'b1, mF[4], 4'h0};
          mCyc = mCyc + 8;
        end else begin
          mHalt = 1; t = "R12";
        end
      end
      8'h20: begin
        b = refRead(mPC); pushBus(1, mPC, 0, t); mPC = mPC + 1;
        if (!mF[7]) begin mPC = mPC + {{8{b[7]}}, b}; mCyc = mCyc + 16; end
        else mCyc = mCyc + 12;
      end
      8'h0E, 8'h3E: begin
        b = refRead(mPC); pushBus(1, mPC, 0, t); mPC = mPC + 1;
        if (op == 8'h0E) mC = b; else mA = b;
        mCyc = mCyc + 8;
      end
      8'h0C: begin
        hc = (mC[3:0] == 4'hF);
        mC = mC + 1;
        mF = {(mC == 8'h00), 1'b0, hc, mF[4], 4'h0};
        mCyc = mCyc + 4;
      end
      8'hE2: begin refWrite({8'hFF, mC}, t); mCyc = mCyc + 8; end
      8'hE0: begin
        b = refRead(mPC); pushBus(1, mPC, 0, t); mPC = mPC + 1;
        refWrite({8'hFF, b}, t);
        mCyc = mCyc + 12;
      end
      8'h1A: begin
        pushBus(1, {mD, mE}, 0, t);
        mA = refRead({mD, mE});
        mCyc = mCyc + 8;
      end
      default: mHalt = 1;
    endcase
    lastTag = t;
  endtask

  task automatic checkState();
    check(pcOut == mPC, lastTag, "pc", $sformatf("%h", pcOut), $sformatf("%h", mPC));
    check(spOut == mSP, lastTag, "sp", $sformatf("%h", spOut), $sformatf("%h", mSP));
    check({regAF, regBC, regDE, regHL} == {mA, mF, mB, mC, mD, mE, mH, mL}, lastTag, "regs",
          $sformatf("%h %h %h %h", regAF, regBC, regDE, regHL),
          $sformatf("%h%h %h%h %h%h %h%h", mA, mF, mB, mC, mD, mE, mH, mL));
    check(cycleCount == mCyc, lastTag, "cycles", $sformatf("%0d", cycleCount), $sformatf("%0d", mCyc));
    check(illegalOp == mHalt, lastTag, "illegal", $sformatf("%0b", illegalOp), $sformatf("%0b", mHalt));
  endtask

  // one clock of comparison, performed at the falling edge
  task automatic tick();
    int k;
    string t;
    if (qKind.size() == 0) begin
      checkState();
      if (!mHalt) execInstr();
    end
    if (qKind.size() > 0) begin
      k = qKind.pop_front();
      t = qTag.pop_front();
      if (k == 1)
        check(memRd && !memWr && memAddr == qAddr[0], t, "bus read",
              $sformatf("rd=%0b wr=%0b a=%h", memRd, memWr, memAddr), $sformatf("rd a=%h", qAddr[0]));
      else if (k == 2)
        check(memWr && !memRd && memAddr == qAddr[0] && memWData == qData[0], t, "bus write",
              $sformatf("rd=%0b wr=%0b a=%h d=%h", memRd, memWr, memAddr, memWData),
              $sformatf("wr a=%h d=%h", qAddr[0], qData[0]));
      else
        check(!memRd && !memWr, t, "bus idle",
              $sformatf("rd=%0b wr=%0b", memRd, memWr), "idle");
      void'(qAddr.pop_front());
      void'(qData.pop_front());
    end else begin
      // R12: a stopped core leaves the bus quiet
      check(!memRd && !memWr && illegalOp, "R12", "halted bus",
            $sformatf("rd=%0b wr=%0b ill=%0b", memRd, memWr, illegalOp), "idle, ill=1");
    end
    if (memWr) busMem[memAddr] = memWData;
    memRData = busRead(memAddr);
  endtask

  task automatic loadProg(input bit [7:0] bytes[$]);
    busMem.delete();
    refMem.delete();
    foreach (bytes[i]) begin
      busMem[16'(i)] = bytes[i];
      refMem[16'(i)] = bytes[i];
    end
  endtask

  task automatic runProg();
    int tail;
    rstN = 1'b0;
    refReset();
    repeat (3) begin
      @(negedge clk);
      memRData = busRead(memAddr);
    end
    rstN = 1'b1;
    tick(); // R1: reset values are checked at the first boundary
    tail = 0;
    while (tail < 4) begin
      @(negedge clk);
      tick();
      if (mHalt && qKind.size() == 0) tail++;
    end
  endtask

  initial begin
    bit [7:0] p[$];
    // Program 1: stack set-up, short clear loop (R4, R6, R7 back-branch), I/O writes, header read
    p = '{8'h31, 8'hFE, 8'hFF, 8'hAF, 8'h21, 8'h03, 8'h80, 8'h32, 8'hCB, 8'h7C,
          8'h20, 8'hFB, 8'h21, 8'h26, 8'hFF, 8'h0E, 8'h11, 8'h3E, 8'h80, 8'h32,
          8'hE2, 8'h0C, 8'h3E, 8'hF3, 8'hE2, 8'h32, 8'h3E, 8'h77, 8'h77, 8'h3E,
          8'hFC, 8'hE0, 8'h47, 8'h11, 8'h04, 8'h01, 8'h21, 8'h10, 8'h80, 8'h1A,
          8'h00};
    loadProg(p);
    busMem[16'h0104] = 8'hCE;
    refMem[16'h0104] = 8'hCE;
    runProg();

    // Program 2: BC load, R9 corners, R7 not-taken and forward taken, E0 at 0xFF, R11, bad CB suffix
    p = '{8'h01, 8'h34, 8'h12, 8'h0E, 8'hFF, 8'h0C, 8'h0E, 8'h0F, 8'h0C, 8'h0E,
          8'h7F, 8'h0C, 8'h21, 8'h00, 8'h00, 8'hCB, 8'h7C, 8'h20, 8'h05, 8'h21,
          8'h00, 8'h80, 8'hCB, 8'h7C, 8'h20, 8'h02, 8'hFF, 8'hFF, 8'h3E, 8'h5A,
          8'hE0, 8'hFF, 8'h11, 8'h00, 8'hC0, 8'h1A, 8'h3E, 8'h33, 8'hAF, 8'hCB,
          8'h11};
    loadProg(p);
    busMem[16'hC000] = 8'h99;
    refMem[16'hC000] = 8'h99;
    runProg();

    // Program 3: unsupported opcode at the very first fetch (R12)
    p = '{8'hD3, 8'h3E, 8'h11};
    loadProg(p);
    runProg();

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule